// File: doc/BRIEF.md
# Oversampling Serial Receive Recovery Unit

This block pulls serial frames out of an asynchronous receive line. It runs on the system clock. A one-cycle sample-tick enable marks each oversampling instant, and the line is examined only on those cycles. A mode input sets the bit period: either 16 samples per bit or 8 samples per bit.

While idle, the block waits for the line to fall. It then checks the start bit with a majority vote on its centre samples, and a failed check throws the event away as a noise spike. An accepted start bit re-aligns the sample counter, which then measures every later bit. Each data bit, the optional parity bit and the first stop bit are decided by a 2-of-3 vote on the three centre samples of the bit.

The byte and two error flags are registered and held. A one-clock strobe marks each completed frame.

Top module: `uart_rx_recover`

## Requirements
- R1: The receive line passes through a two-stage synchronizer, and its level is looked at only on clock cycles where `smp_tick` is high.
- R2: In idle, after the line has been seen high, the first tick that sees it low is sample 1 of a start bit. The start bit is accepted when at least two of samples 8, 9, 10 (8, 9, 10 with `fast_mode`=0; 4, 5, 6 with `fast_mode`=1) are low.
- R3: When two or more of those start samples are high, the event is discarded with no strobe. The block then needs a high tick followed by a low tick before it starts again.
- R4: `fast_mode`=0 gives 16 samples per bit and `fast_mode`=1 gives 8. The sample counter restarts at 1 on every accepted start bit.
- R5: Each later bit takes the majority value of its samples 8, 9, 10 (normal) or 4, 5, 6 (double speed). Samples outside those three have no effect.
- R6: Eight data bits follow the start bit, least significant bit first, and appear on `rx_data` with bit 0 as the first data bit.
- R7: With `par_en`=1, a parity bit follows the data. `par_err` is set when the XOR of the eight data bits and the parity bit differs from `par_odd` (0 = even, 1 = odd). With `par_en`=0 there is no parity bit and `par_err` is 0.
- R8: Only the first stop bit is voted. A voted 0 sets `frm_err` together with the strobe.
- R9: `rx_valid` is high for exactly the one clock after the tick that decides the stop bit. `rx_data`, `par_err` and `frm_err` change only with that strobe.
- R10: After the stop-bit decision the block is idle and armed, so the very next tick that sees the line low starts a new frame.
- R11: After reset `rx_valid`, `rx_data`, `par_err` and `frm_err` are all 0 and the block is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| smp_tick | input | 1 | Oversampling enable, one clock per sample |
| fast_mode | input | 1 | 0: 16 samples per bit, 1: 8 samples per bit |
| par_en | input | 1 | A parity bit follows the data |
| par_odd | input | 1 | 0: even parity, 1: odd parity |
| rx_in | input | 1 | Asynchronous receive line |
| rx_data | output | DATA_W | Last received byte |
| rx_valid | output | 1 | One-clock frame-complete strobe |
| par_err | output | 1 | Parity mismatch of the last frame |
| frm_err | output | 1 | Stop bit of the last frame voted low |

## Verification
A level driven on the line needs two synchronizer clocks before a tick can sample it. The bench therefore changes the line on the falling edge just after a tick and spaces ticks four clocks apart, so each driven level is exactly the level seen by the next tick. The strobe is due in the single clock that follows the tick carrying stop sample 10 (or 6). The bench model annotates that tick in its per-tick stimulus queue and checks the strobe on every falling edge. It also checks, on every falling edge, the held byte and flags against the last completed frame.

// File: rtl/rxr_pkg.sv
package rxr_pkg;
  typedef enum logic [1:0] {
    RX_IDLE  = 2'd0,
    RX_START = 2'd1,
    RX_BITS  = 2'd2
  } rx_state_e;
endpackage

// File: rtl/rxr_sync.sv
module rxr_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] ff_q;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) ff_q[g] <= 1'b1;
          else     ff_q[g] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) ff_q[g] <= 1'b1;
          else     ff_q[g] <= ff_q[g-1];
        end
      end
    end
  endgenerate

  assign q = ff_q[STAGES-1];
endmodule

// File: rtl/rxr_phase.sv
module rxr_phase #(
  parameter int SPB_NORM = 16,
  parameter int SPB_FAST = 8,
  parameter int CNT_W    = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             fast,
  input  logic             restart,
  output logic             is_lo,
  output logic             is_mid,
  output logic             is_hi,
  output logic [CNT_W-1:0] cnt_q
);
  logic [CNT_W-1:0] spb;
  logic [CNT_W-1:0] lo;
  logic [CNT_W-1:0] nxt;

  always_comb begin
    spb = fast ? CNT_W'(SPB_FAST) : CNT_W'(SPB_NORM);
    lo  = spb >> 1;
    if (restart || cnt_q >= spb) nxt = CNT_W'(1);
    else                         nxt = cnt_q + CNT_W'(1);
    is_lo  = (nxt == lo);
    is_mid = (nxt == lo + CNT_W'(1));
    is_hi  = (nxt == lo + CNT_W'(2));
  end

  always_ff @(posedge clk) begin
    if (rst)       cnt_q <= '0;
    else if (tick) cnt_q <= nxt;
  end
endmodule

// File: rtl/rxr_vote.sv
module rxr_vote (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic din,
  input  logic is_lo,
  input  logic is_mid,
  output logic maj
);
  logic s_lo_q;
  logic s_mid_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      s_lo_q  <= 1'b1;
      s_mid_q <= 1'b1;
    end else if (tick) begin
      if (is_lo)  s_lo_q  <= din;
      if (is_mid) s_mid_q <= din;
    end
  end

  assign maj = (s_lo_q & s_mid_q) | (s_lo_q & din) | (s_mid_q & din);
endmodule

// File: rtl/uart_rx_recover.sv
module uart_rx_recover
  import rxr_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SPB_NORM    = 16,
  parameter int SPB_FAST    = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              smp_tick,
  input  logic              fast_mode,
  input  logic              par_en,
  input  logic              par_odd,
  input  logic              rx_in,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_valid,
  output logic              par_err,
  output logic              frm_err
);
  localparam int CNT_W = $clog2(SPB_NORM + 1);
  localparam int IDX_W = $clog2(DATA_W + 3);

  logic              rx_s;
  logic              is_lo, is_mid, is_hi;
  logic [CNT_W-1:0]  cnt_q;
  logic              maj;
  rx_state_e         state_q;
  logic              armed_q;
  logic [IDX_W-1:0]  idx_q;
  logic [DATA_W-1:0] shift_q;
  logic              par_q;
  logic              restart;

  assign restart = (state_q == RX_IDLE);

  rxr_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d(rx_in), .q(rx_s)
  );

  rxr_phase #(.SPB_NORM(SPB_NORM), .SPB_FAST(SPB_FAST), .CNT_W(CNT_W)) u_phase (
    .clk(clk), .rst(rst), .tick(smp_tick), .fast(fast_mode), .restart(restart),
    .is_lo(is_lo), .is_mid(is_mid), .is_hi(is_hi), .cnt_q(cnt_q)
  );

  rxr_vote u_vote (
    .clk(clk), .rst(rst), .tick(smp_tick), .din(rx_s),
    .is_lo(is_lo), .is_mid(is_mid), .maj(maj)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= RX_IDLE;
      armed_q  <= 1'b0;
      idx_q    <= '0;
      shift_q  <= '0;
      par_q    <= 1'b0;
      rx_data  <= '0;
      rx_valid <= 1'b0;
      par_err  <= 1'b0;
      frm_err  <= 1'b0;
    end else begin
      rx_valid <= 1'b0;
      if (smp_tick) begin
        unique case (state_q)
          RX_IDLE: begin
            if (rx_s)         armed_q <= 1'b1;
            else if (armed_q) state_q <= RX_START;
          end
          RX_START: begin
            if (is_hi) begin
              if (!maj) begin
                state_q <= RX_BITS;
                idx_q   <= '0;
              end else begin
                state_q <= RX_IDLE;
                armed_q <= 1'b0;
              end
            end
          end
          RX_BITS: begin
            if (is_hi) begin
              idx_q <= idx_q + IDX_W'(1);
              if (idx_q < IDX_W'(DATA_W)) begin
                shift_q <= {maj, shift_q[DATA_W-1:1]};
              end else if (idx_q == IDX_W'(DATA_W) && par_en) begin
                par_q <= maj;
              end else begin
                rx_data  <= shift_q;
                par_err  <= par_en & ((^shift_q ^ par_q) != par_odd);
                frm_err  <= ~maj;
                rx_valid <= 1'b1;
                state_q  <= RX_IDLE;
                armed_q  <= 1'b1;
              end
            end
          end
          default: state_q <= RX_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/rxr_chk.sv
module rxr_chk
  import rxr_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int CNT_W    = 5,
  parameter int SPB_NORM = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              smp_tick,
  input logic              par_en,
  input logic [DATA_W-1:0] rx_data,
  input logic              rx_valid,
  input logic              par_err,
  input logic              frm_err,
  input rx_state_e         state,
  input logic [CNT_W-1:0]  cnt
);
  assert_strobe_single_R9: assert property (@(posedge clk) disable iff (rst)
    rx_valid |=> !rx_valid);

  assert_strobe_after_tick_R9: assert property (@(posedge clk) disable iff (rst)
    rx_valid |-> $past(smp_tick));

  assert_outputs_held_R9: assert property (@(posedge clk) disable iff (rst)
    !rx_valid |-> ($stable(rx_data) && $stable(par_err) && $stable(frm_err)));

  assert_no_parity_flag_R7: assert property (@(posedge clk) disable iff (rst)
    (rx_valid && !$past(par_en)) |-> !par_err);

  assert_counter_range_R4: assert property (@(posedge clk) disable iff (rst)
    cnt <= CNT_W'(SPB_NORM));

  assert_strobe_from_bits_R6: assert property (@(posedge clk) disable iff (rst)
    rx_valid |-> ($past(state) == RX_BITS && state == RX_IDLE));

  assert_counter_still_R1: assert property (@(posedge clk) disable iff (rst)
    !$past(smp_tick) |-> $stable(cnt));
endmodule

bind uart_rx_recover rxr_chk #(.DATA_W(DATA_W), .CNT_W(CNT_W), .SPB_NORM(SPB_NORM)) u_chk (
  .clk(clk), .rst(rst), .smp_tick(smp_tick), .par_en(par_en),
  .rx_data(rx_data), .rx_valid(rx_valid), .par_err(par_err), .frm_err(frm_err),
  .state(state_q), .cnt(cnt_q)
);

// File: tb/sim_uart_rx_recover.sv
module sim_uart_rx_recover;
  typedef struct {
    logic       lvl;
    bit         ev;
    logic [7:0] d;
    bit         pe;
    bit         fe;
    string      tag;
  } ent_t;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       smp_tick = 1'b0;
  logic       fast_mode = 1'b0;
  logic       par_en = 1'b0;
  logic       par_odd = 1'b0;
  logic       rx_in = 1'b1;
  logic [7:0] rx_data;
  logic       rx_valid, par_err, frm_err;

  uart_rx_recover u0 (
    .clk(clk), .rst(rst), .smp_tick(smp_tick), .fast_mode(fast_mode),
    .par_en(par_en), .par_odd(par_odd), .rx_in(rx_in),
    .rx_data(rx_data), .rx_valid(rx_valid), .par_err(par_err), .frm_err(frm_err)
  );

  always #5 clk = ~clk;

  int   n_chk = 0;
  int   n_bad = 0;
  bit   drv_on = 1'b0;
  bit   have = 1'b0;
  bit   done = 1'b0;
  int   tdiv = 0;
  ent_t pend, held;
  ent_t line_q[$];

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic ent_t mk(logic l, string t);
    ent_t e;
    e.lvl = l; e.ev = 1'b0; e.d = 8'h00; e.pe = 1'b0; e.fe = 1'b0; e.tag = t;
    return e;
  endfunction

  task automatic add_idle(int n, string t);
    for (int i = 0; i < n; i++) line_q.push_back(mk(1'b1, t));
  endtask

  // Noise spike: nlow low ticks, then a long high stretch.
  task automatic add_glitch(int nlow, string t);
    int spb;
    spb = fast_mode ? 8 : 16;
    for (int i = 0; i < nlow; i++) line_q.push_back(mk(1'b0, t));
    add_idle(3 * spb, t);
  endtask

  // One frame, built per tick; flip = tick index (from sample 1) to invert.
  task automatic add_frame(logic [7:0] d, bit bad_par, bit bad_stop, bit trunc, int flip, string t);
    int   spb, lo, hi, nb, k;
    logic bits [0:10];
    ent_t e;
    spb = fast_mode ? 8 : 16;
    lo = spb / 2;
    hi = lo + 2;
    nb = par_en ? 11 : 10;
    k = 0;
    bits[0] = 1'b0;
    for (int i = 0; i < 8; i++) bits[i+1] = d[i];
    if (par_en) bits[9] = (par_odd ? ~^d : ^d) ^ bad_par;
    bits[nb-1] = 1'b1;
    for (int b = 0; b < nb; b++) begin
      for (int s = 1; s <= spb; s++) begin
        if (!(b == nb - 1 && trunc && s > hi)) begin
          e = mk(bits[b], t);
          if (b == nb - 1 && bad_stop && s >= lo && s <= hi) e.lvl = 1'b0;
          if (k == flip) e.lvl = ~e.lvl;
          if (b == nb - 1 && s == hi) begin
            e.ev = 1'b1; e.d = d; e.pe = par_en & bad_par; e.fe = bad_stop;
          end
          line_q.push_back(e);
          k++;
        end
      end
    end
  endtask

  task automatic drain();
    wait (line_q.size() == 0);
    repeat (80) @(negedge clk);
  endtask

  // Per-clock driver and comparison against the per-tick reference queue.
  initial begin
    pend = mk(1'b1, "R9");
    forever begin
      @(negedge clk);
      if (drv_on) begin
        if (smp_tick) begin
          chk(pend.tag, "valid at tick", rx_valid, pend.ev);
          if (pend.ev) begin
            held = pend;
            have = 1'b1;
          end
          if (line_q.size() > 0) pend = line_q.pop_front();
          else                   pend = mk(1'b1, "R9");
          rx_in = pend.lvl;
        end else begin
          chk("R9", "valid between ticks", rx_valid, 0);
        end
        if (have) begin
          chk(held.tag, "data", rx_data, held.d);
          chk(held.tag, "parity error", par_err, held.pe);
          chk(held.tag, "framing error", frm_err, held.fe);
        end
        tdiv = (tdiv == 3) ? 0 : tdiv + 1;
        smp_tick = (tdiv == 0);
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    int spb;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R11", "valid after reset", rx_valid, 0);
    chk("R11", "data after reset", rx_data, 0);
    chk("R11", "parity error after reset", par_err, 0);
    chk("R11", "framing error after reset", frm_err, 0);
    drv_on = 1'b1;

    // Normal mode, 16 samples per bit, no parity.
    spb = 16;
    add_idle(30, "R1");
    add_frame(8'hA5, 0, 0, 0, -1, "R1");
    add_idle(20, "R6");
    add_frame(8'h3C, 0, 0, 0, -1, "R6");
    add_idle(20, "R4");
    add_frame(8'h81, 0, 0, 0, -1, "R4");
    add_idle(20, "R5");
    add_frame(8'h00, 0, 0, 0, 3 * spb + spb / 2, "R5");   // centre sample of data bit 2
    add_idle(20, "R5");
    add_frame(8'hFF, 0, 0, 0, 4 * spb + 1, "R5");        // sample 2 of data bit 3
    add_idle(20, "R2");
    add_frame(8'h5A, 0, 0, 0, spb / 2, "R2");            // start sample 9 high
    add_idle(20, "R3");
    add_glitch(3, "R3");
    add_glitch(spb / 2, "R3");                            // samples 9 and 10 high
    add_frame(8'hC3, 0, 0, 0, -1, "R3");
    add_idle(20, "R8");
    add_frame(8'h77, 0, 1, 0, -1, "R8");
    add_idle(20, "R10");
    add_frame(8'h12, 0, 0, 1, -1, "R10");
    add_frame(8'hED, 0, 0, 0, -1, "R10");
    add_idle(20, "R9");
    drain();

    // Parity checking, even then odd.
    par_en = 1'b1;
    par_odd = 1'b0;
    add_idle(20, "R7");
    add_frame(8'h6B, 0, 0, 0, -1, "R7");
    add_idle(20, "R7");
    add_frame(8'h6B, 1, 0, 0, -1, "R7");
    drain();
    par_odd = 1'b1;
    add_idle(20, "R7");
    add_frame(8'h94, 0, 0, 0, -1, "R7");
    add_idle(20, "R7");
    add_frame(8'h95, 1, 0, 0, -1, "R7");
    add_idle(20, "R7");
    drain();

    // Double-speed mode, 8 samples per bit.
    par_en = 1'b0;
    fast_mode = 1'b1;
    spb = 8;
    add_idle(20, "R4");
    add_frame(8'h2E, 0, 0, 0, -1, "R4");
    add_idle(20, "R5");
    add_frame(8'hF0, 0, 0, 0, 5 * spb + spb / 2, "R5");
    add_idle(20, "R3");
    add_glitch(spb / 2, "R3");
    add_frame(8'h0F, 0, 0, 0, -1, "R3");
    add_idle(20, "R8");
    add_frame(8'hB1, 0, 1, 0, -1, "R8");
    add_idle(20, "R10");
    add_frame(8'h4D, 0, 0, 1, -1, "R10");
    add_frame(8'hD4, 0, 0, 0, -1, "R10");
    add_idle(10, "R7");
    drain();
    par_en = 1'b1;
    par_odd = 1'b0;
    add_idle(20, "R7");
    add_frame(8'h37, 1, 0, 0, -1, "R7");
    add_idle(20, "R9");
    drain();

    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule